// File: doc/BRIEF.md
# Mark-Aligned Byte Deserializer with Ready Flag

This block turns the serial NRZ read stream of a disk read channel into bytes once an upstream detector has found an address mark. While the mark-found input is held high, every accepted bit strobe from the recovered clock shifts one data bit into a shift register. A modulo-`DATA_W` bit counter frames the bytes. It starts at zero when the mark is found, so byte boundaries are anchored to that event. On every `DATA_W`-th bit, the assembled byte is copied into a holding latch and a ready flag is raised.

A polling processor reads the block through two strobes. The status strobe returns the ready and overrun bits. The data strobe returns the held byte and clears the ready flag. Each read is placed on a shared bus as a registered value together with a registered drive-enable, so the pair maps directly onto a tri-state buffer. The most significant shift stage and a delayed copy of each accepted bit strobe are also brought out, for a downstream CRC checker.

Everything runs on one system clock. The recovered clock arrives as a one-cycle bit-enable pulse.

Top module: `mark_deser`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `bus_oe`, `bus_q`, `crc_bit` and `crc_tick` are all 0, and no byte is ready.
- R2: While `mark_ok` is low, bit strobes are ignored. The ready and overrun bits read 0, `crc_bit` and `crc_tick` stay 0, and the partial bit count and shift contents are cleared.
- R3: Bits are taken MSB first. The first bit accepted after `mark_ok` rises lands in bit `DATA_W-1` of the byte, and each group of `DATA_W` accepted bits forms one byte.
- R4: In the cycle after the strobe carrying a byte's last bit, the ready bit (status bit 0) reads 1.
- R5: One cycle after `rd_data` is pulsed, `bus_oe` is 1 and `bus_q` holds the latched byte as it stood before that edge. The ready bit is then 0, unless a new byte completed on that same edge.
- R6: One cycle after `rd_stat` is pulsed (and `rd_data` is low), `bus_oe` is 1 and `bus_q` is {zeros, overrun, ready} as they stood before that edge. The status read clears overrun, unless a new overrun is set on that same edge.
- R7: If a byte completes while ready is still 1 and no data read occurs in that cycle, the latch is overwritten with the new byte and overrun (status bit 1) becomes 1.
- R8: When a data read and a byte completion fall in the same cycle, the read returns the previous byte, ready stays 1 for the new byte, and overrun is not set.
- R9: When both strobes are high in the same cycle, the data read is performed and the status strobe is ignored.
- R10: `crc_tick` is 1 exactly in the cycle after each accepted bit strobe. `crc_bit` is the bit accepted `DATA_W-1` strobes before the latest one, or 0 if fewer than `DATA_W` bits have been accepted since the mark.
- R11: In a cycle after one with neither strobe high, `bus_oe` is 0 and `bus_q` is 0.
- R12: Dropping `mark_ok` in the middle of a byte discards the partial bits. After `mark_ok` rises again, framing restarts from the first new bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mark_ok | input | 1 | Address mark found, held high while reading |
| bit_en | input | 1 | One-cycle pulse per recovered bit |
| nrz_in | input | 1 | NRZ data bit, valid with `bit_en` |
| rd_data | input | 1 | Processor data read strobe |
| rd_stat | input | 1 | Processor status read strobe |
| bus_q | output | DATA_W | Registered read value for the shared bus |
| bus_oe | output | 1 | Registered drive enable for the bus buffer |
| crc_bit | output | 1 | Most significant shift stage, for the CRC checker |
| crc_tick | output | 1 | Delayed copy of each accepted bit strobe |

## Verification
The race that matters is a data read landing on the same edge as the last bit of the next byte. Here the latch load, the ready-flag set and the ready-flag clear all compete. A directed sequence places `rd_data` exactly on the eighth strobe. The bench then expects the bus to carry the older byte, ready to remain 1, and overrun to stay 0.

A second overlap pairs the completion of an unread byte with a status read, so that setting and clearing overrun fall on one edge. Both cases are also reached by a long random stretch. Every cycle is compared against a queue-based model in the bench.

// File: rtl/mark_deser_pkg.sv
package mark_deser_pkg;

  typedef struct packed {
    logic ovr;
    logic rdy;
  } deser_flags_t;

  function automatic logic [1:0] flag_bits(deser_flags_t f);
    return {f.ovr, f.rdy};
  endfunction

endpackage

// File: rtl/deser_bitcount.sv
module deser_bitcount #(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic tick,
  output logic wrap
);
  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  logic [CW-1:0] cnt;

  assign wrap = arm && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !arm) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  // R3
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (arm && tick && cnt == LAST) |=> (cnt == '0));

  // R2
  cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!arm) |=> (cnt == '0));

endmodule

// File: rtl/deser_shifter.sv
module deser_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              tick,
  input  logic              din,
  input  logic              wrap,
  output logic [DATA_W-1:0] held,
  output logic              tap,
  output logic              tick_q
);
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] sh_nxt;

  assign sh_nxt = {sh[DATA_W-2:0], din};
  assign tap    = sh[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst || !arm) begin
      sh <= '0;
    end else if (tick) begin
      sh <= sh_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
    end else if (wrap) begin
      held <= sh_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= arm && tick;
  end

  // R10
  tick_echo_chk: assert property (@(posedge clk) disable iff (rst)
    (arm && tick) |=> tick_q);

  // R3
  held_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!wrap) |=> $stable(held));

endmodule

// File: rtl/deser_flags.sv
module deser_flags
  import mark_deser_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         arm,
  input  logic         wrap,
  input  logic         take_data,
  input  logic         take_stat,
  output deser_flags_t flags
);

  always_ff @(posedge clk) begin
    if (rst || !arm) begin
      flags.rdy <= 1'b0;
    end else if (wrap) begin
      flags.rdy <= 1'b1;
    end else if (take_data) begin
      flags.rdy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !arm) begin
      flags.ovr <= 1'b0;
    end else if (wrap && flags.rdy && !take_data) begin
      flags.ovr <= 1'b1;
    end else if (take_stat) begin
      flags.ovr <= 1'b0;
    end
  end

  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    (arm && wrap && flags.rdy && !take_data) |=> flags.ovr);

  // R8
  collide_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (arm && wrap && take_data) |=> flags.rdy);

  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (take_data && !wrap) |=> !flags.rdy);

  // R2
  idle_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (!arm) |=> (!flags.rdy && !flags.ovr));

endmodule

// File: rtl/mark_deser.sv
module mark_deser
  import mark_deser_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mark_ok,
  input  logic              bit_en,
  input  logic              nrz_in,
  input  logic              rd_data,
  input  logic              rd_stat,
  output logic [DATA_W-1:0] bus_q,
  output logic              bus_oe,
  output logic              crc_bit,
  output logic              crc_tick
);
  localparam int PAD_W = DATA_W - 2;

  logic              wrap;
  logic [DATA_W-1:0] held;
  deser_flags_t      flags;
  logic              take_data;
  logic              take_stat;
  logic [DATA_W-1:0] stat_word;

  assign take_data = rd_data;
  assign take_stat = rd_stat && !rd_data;
  assign stat_word = {{PAD_W{1'b0}}, flag_bits(flags)};

  deser_bitcount #(.DATA_W(DATA_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .arm  (mark_ok),
    .tick (bit_en),
    .wrap (wrap)
  );

  deser_shifter #(.DATA_W(DATA_W)) u_sh (
    .clk    (clk),
    .rst    (rst),
    .arm    (mark_ok),
    .tick   (bit_en),
    .din    (nrz_in),
    .wrap   (wrap),
    .held   (held),
    .tap    (crc_bit),
    .tick_q (crc_tick)
  );

  deser_flags u_flg (
    .clk       (clk),
    .rst       (rst),
    .arm       (mark_ok),
    .wrap      (wrap),
    .take_data (take_data),
    .take_stat (take_stat),
    .flags     (flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_q  <= '0;
      bus_oe <= 1'b0;
    end else if (take_data) begin
      bus_q  <= held;
      bus_oe <= 1'b1;
    end else if (take_stat) begin
      bus_q  <= stat_word;
      bus_oe <= 1'b1;
    end else begin
      bus_q  <= '0;
      bus_oe <= 1'b0;
    end
  end

  // R11
  bus_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_data && !rd_stat) |=> (!bus_oe && bus_q == '0));

  // R9
  data_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data && rd_stat) |=> (bus_oe && bus_q == $past(held)));

endmodule

// File: tb/sim_mark_deser.sv
module sim_mark_deser;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mark_ok = 0, bit_en = 0, nrz_in = 0, rd_data = 0, rd_stat = 0;
  logic [W-1:0] bus_q;
  logic bus_oe, crc_bit, crc_tick;

  always #2 clk = ~clk;

  mark_deser #(.DATA_W(W)) u0 (
    .clk(clk), .rst(rst), .mark_ok(mark_ok), .bit_en(bit_en), .nrz_in(nrz_in),
    .rd_data(rd_data), .rd_stat(rd_stat), .bus_q(bus_q), .bus_oe(bus_oe),
    .crc_bit(crc_bit), .crc_tick(crc_tick)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  bit hist[$];
  int total = 0;
  logic [W-1:0] m_latch = 0, m_out = 0;
  bit m_rdy = 0, m_ovr = 0, m_oe = 0, m_tap = 0, m_tick = 0;

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all(string tag);
    chk({tag, " bus_oe R11"}, W'(bus_oe), W'(m_oe));
    chk({tag, " bus_q R5"}, bus_q, m_out);
    chk({tag, " crc_bit R10"}, W'(crc_bit), W'(m_tap));
    chk({tag, " crc_tick R10"}, W'(crc_tick), W'(m_tick));
  endtask

  // Behavioural model for one edge, using the inputs just driven
  task automatic model_step(bit mk, bit be, bit d, bit rd, bit st);
    bit done = 0;
    logic [W-1:0] nb = 0;
    bit old_rdy = m_rdy;
    if (rd) begin m_out = m_latch; m_oe = 1; end
    else if (st) begin m_out = W'({m_ovr, m_rdy}); m_oe = 1; end
    else begin m_out = 0; m_oe = 0; end
    if (!mk) begin
      hist.delete(); total = 0; m_rdy = 0; m_ovr = 0; m_tick = 0; m_tap = 0;
    end else begin
      m_tick = be;
      if (be) begin
        hist.push_back(d); total++;
        if (hist.size() > W) void'(hist.pop_front());
        m_tap = (hist.size() == W) ? hist[0] : 0;
        if (total % W == 0) begin
          done = 1;
          for (int i = 0; i < W; i++) nb[W-1-i] = hist[i];
        end
      end
      if (done && old_rdy && !rd) m_ovr = 1;
      else if (st && !rd) m_ovr = 0;
      if (done) begin m_rdy = 1; m_latch = nb; end
      else if (rd) m_rdy = 0;
    end
  endtask

  task automatic cyc(string tag, bit mk, bit be, bit d, bit rd, bit st);
    @(negedge clk);
    compare_all(tag);
    mark_ok = mk; bit_en = be; nrz_in = d; rd_data = rd; rd_stat = st;
    model_step(mk, be, d, rd, st);
  endtask

  task automatic send_byte(string tag, logic [W-1:0] b, int gap);
    for (int i = W - 1; i >= 0; i--) begin
      cyc(tag, 1, 1, b[i], 0, 0);
      for (int g = 0; g < gap; g++) cyc(tag, 1, 0, 0, 0, 0);
    end
  endtask

  initial begin
    for (int t = 0; t < 150000; t++) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      compare_all("R1 reset");
    end
    rst = 0;
    cyc("R1 post", 0, 0, 0, 0, 0);
    // R2: strobes with mark low are ignored, status reads 0
    for (int i = 0; i < 10; i++) cyc("R2 idle", 0, 1, i[0], 0, 0);
    cyc("R2 stat", 0, 0, 0, 0, 1);
    cyc("R2 after", 0, 0, 0, 0, 0);
    // R3 R4: MSB-first byte, ready bit set
    send_byte("R3 byteA5", 8'hA5, 2);
    cyc("R4 stat", 1, 0, 0, 0, 1);
    // R5: data read clears ready
    cyc("R5 read", 1, 0, 0, 1, 0);
    cyc("R5 stat", 1, 0, 0, 0, 1);
    cyc("R11 idle", 1, 0, 0, 0, 0);
    // R7 R6: overrun then status clears it
    send_byte("R7 b1", 8'h3C, 0);
    send_byte("R7 b2", 8'hC3, 1);
    cyc("R6 stat", 1, 0, 0, 0, 1);
    cyc("R6 stat2", 1, 0, 0, 0, 1);
    cyc("R7 read", 1, 0, 0, 1, 0);
    // R8: read on the same edge as the last bit
    send_byte("R8 b1", 8'h81, 0);
    for (int i = W - 1; i > 0; i--) cyc("R8 b2", 1, 1, i[0], 0, 0);
    cyc("R8 hit", 1, 1, 1, 1, 0);
    cyc("R8 stat", 1, 0, 0, 0, 1);
    // R9: both strobes, data wins
    cyc("R9 both", 1, 0, 0, 1, 1);
    cyc("R9 stat", 1, 0, 0, 0, 1);
    // R12: drop mark mid-byte, restart framing
    for (int i = 0; i < 5; i++) cyc("R12 part", 1, 1, 1, 0, 0);
    cyc("R12 drop", 0, 0, 0, 0, 0);
    send_byte("R12 new", 8'h5A, 1);
    cyc("R12 read", 1, 0, 0, 1, 0);
    // random stretch, all requirements compared each cycle
    for (int i = 0; i < 4000; i++) begin
      bit mk = ($urandom % 100) != 0;
      cyc("rand", mk, ($urandom % 3) == 0, $urandom % 2,
          ($urandom % 9) == 0, ($urandom % 11) == 0);
    end
    cyc("tail", 0, 0, 0, 0, 0);
    cyc("tail", 0, 0, 0, 0, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule